// File: doc/BRIEF.md
# Resistor Code Key Classifier with Debounce

This block takes a stream of 8-bit conversion results, each describing the resistance currently seen on a remote-control sense line. It sorts every sample into one of thirty key windows or one of two jack windows, and treats the gaps between windows as invalid. A classification becomes the new stable state only after a run of identical valid samples. Each time the stable state changes, the block emits exactly one event carrying an 8-bit key byte. This covers a key press, a return to the open line, and a move straight from one key to another. The event goes to a key-event FIFO downstream.

Samples enter on a valid/ready stream. An accepted sample is one with `s_valid` and `s_ready` both high on a clock edge. Events leave on a second valid/ready stream. The output holds a single event register. While an event waits with `m_ready` low, `s_ready` stays low, which stalls the sample source. Samples are never dropped and events are never overwritten. `s_ready` is high whenever the output register is empty, or is being emptied in the same cycle.

Monitoring starts as soon as reset is released, with no command needed. A synchronous `shdn` input returns the block to its open-line state.

Top module: `rkc_key_classifier`

## Requirements
- R1: A code inside key window k produces the key byte k, for k = 0..29. The windows (low..high, inclusive) are 0..1, 11..13, 19..21, 27..30, 35..38, 42..46, 50..53, 58..62, 66..70, 74..78, 82..86, 90..94, 98..102, 105..110, 114..119, 123..127, 130..135, 137..142, 146..150, 154..159, 162..166, 170..174, 178..182, 186..190, 194..198, 202..206, 211..214, 218..222, 226..229 and 235..237.
- R2: Codes 243..245 classify as jack inserted, reported as byte 0xF3. Codes 254..255 classify as open line (jack removed), reported as byte 0xFE.
- R3: A code in no window is invalid. It never causes an event, and it clears the run of identical samples, so the run restarts at the next valid sample.
- R4: A classification becomes stable only after DEBOUNCE_N (default 4) consecutive accepted valid samples of that class. A shorter run produces no event. Cycles with `s_valid` low do not break a run.
- R5: An event is emitted only when the newly stable class differs from the previous stable class. This covers releases (key to 0xFE) and direct key-to-key changes. A brief excursion that returns to the stable class produces no event.
- R6: After reset, the stable state is open line (0xFE), `m_valid` is low and `s_ready` is high. The first qualified class other than 0xFE produces an event without any host action.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high, `m_key` holds its value and `s_ready` is low. Otherwise `s_ready` is high.
- R8: While `shdn` is high, samples are discarded and `s_ready` is high. Any pending event is cleared, the stable state returns to 0xFE and the run count clears. After `shdn` falls, a run of open-line codes produces no event.
- R9: The event becomes visible on `m_valid` and `m_key` in the cycle right after the edge that accepts the qualifying DEBOUNCE_N-th sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn | input | 1 | Synchronous shutdown: clears state, suppresses events |
| s_valid | input | 1 | Sample code valid |
| s_ready | output | 1 | Block can accept a sample |
| s_code | input | 8 | Resistance conversion code |
| m_valid | output | 1 | Key event valid |
| m_ready | input | 1 | Downstream accepts the event |
| m_key | output | 8 | Key byte: 0..29, 0xF3 or 0xFE |

## Verification
The bench checks the window edges and the gap codes next to them. A classifier with an off-by-one bound would report a key for a gap code, or miss a key at a window edge. It checks a run broken by an invalid sample, or a run one short of DEBOUNCE_N. A debouncer that failed to clear or mis-counted would emit early on such a run. It also checks a short excursion that returns to the held key, which a design that reports every run would turn into a spurious event. Back-pressure with an event waiting catches designs that overwrite or drop the held key. Shutdown with an event pending catches designs that leak the stale event or keep the old stable key, and so fail to stay quiet on the open line afterwards.

// File: rtl/rkc_pkg.sv
package rkc_pkg;

  localparam int CODE_W    = 8;
  localparam int NUM_KEYS  = 30;
  localparam int NUM_WIN   = NUM_KEYS + 2;
  localparam int WIN_JIN   = NUM_KEYS;
  localparam int WIN_OPEN  = NUM_KEYS + 1;

  localparam logic [CODE_W-1:0] JACK_IN_BYTE = 8'hF3;
  localparam logic [CODE_W-1:0] OPEN_BYTE    = 8'hFE;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] key;
  } cls_t;

  // Lower bound of each classification window (keys, then jack in, then open)
  function automatic logic [CODE_W-1:0] win_lo(input int idx);
    case (idx)
      0: return 8'd0;     1: return 8'd11;    2: return 8'd19;    3: return 8'd27;
      4: return 8'd35;    5: return 8'd42;    6: return 8'd50;    7: return 8'd58;
      8: return 8'd66;    9: return 8'd74;    10: return 8'd82;   11: return 8'd90;
      12: return 8'd98;   13: return 8'd105;  14: return 8'd114;  15: return 8'd123;
      16: return 8'd130;  17: return 8'd137;  18: return 8'd146;  19: return 8'd154;
      20: return 8'd162;  21: return 8'd170;  22: return 8'd178;  23: return 8'd186;
      24: return 8'd194;  25: return 8'd202;  26: return 8'd211;  27: return 8'd218;
      28: return 8'd226;  29: return 8'd235;  30: return 8'd243;  default: return 8'd254;
    endcase
  endfunction

  // Upper bound of each classification window
  function automatic logic [CODE_W-1:0] win_hi(input int idx);
    case (idx)
      0: return 8'd1;     1: return 8'd13;    2: return 8'd21;    3: return 8'd30;
      4: return 8'd38;    5: return 8'd46;    6: return 8'd53;    7: return 8'd62;
      8: return 8'd70;    9: return 8'd78;    10: return 8'd86;   11: return 8'd94;
      12: return 8'd102;  13: return 8'd110;  14: return 8'd119;  15: return 8'd127;
      16: return 8'd135;  17: return 8'd142;  18: return 8'd150;  19: return 8'd159;
      20: return 8'd166;  21: return 8'd174;  22: return 8'd182;  23: return 8'd190;
      24: return 8'd198;  25: return 8'd206;  26: return 8'd214;  27: return 8'd222;
      28: return 8'd229;  29: return 8'd237;  30: return 8'd245;  default: return 8'd255;
    endcase
  endfunction

  // Byte reported for a window
  function automatic logic [CODE_W-1:0] win_byte(input int idx);
    if (idx < NUM_KEYS)      return CODE_W'(idx);
    else if (idx == WIN_JIN) return JACK_IN_BYTE;
    else                     return OPEN_BYTE;
  endfunction

endpackage

// File: rtl/rkc_classifier.sv
module rkc_classifier
  import rkc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cls_t              cls_o
);

  logic [NUM_WIN-1:0] hit;

  // One offset-and-span compare per window: (code - lo) <= (hi - lo)
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [CODE_W-1:0] LO   = win_lo(w);
    localparam logic [CODE_W-1:0] SPAN = win_hi(w) - win_lo(w);
    logic [CODE_W-1:0] ofs;
    assign ofs    = code_i - LO;
    assign hit[w] = (ofs <= SPAN);
  end

  // Windows are disjoint, so at most one hit is set
  always_comb begin
    cls_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit[w]) begin
        cls_o.ok  = 1'b1;
        cls_o.key = win_byte(w);
      end
    end
  end

endmodule

// File: rtl/rkc_debounce.sv
module rkc_debounce
  import rkc_pkg::*;
#(
  parameter int DEBOUNCE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn,
  input  logic              fire,
  input  cls_t              cls_i,
  output logic              emit_o,
  output logic [CODE_W-1:0] emit_key_o
);

  localparam int CNT_W = $clog2(DEBOUNCE_N + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEBOUNCE_N);

  logic [CODE_W-1:0] stable_q, cand_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              same;

  always_comb begin
    same = cls_i.ok && (cls_i.key == cand_q) && (cnt_q != '0);
    if (!cls_i.ok)             cnt_nxt = '0;
    else if (!same)            cnt_nxt = CNT_W'(1);
    else if (cnt_q == CNT_FULL) cnt_nxt = cnt_q;
    else                       cnt_nxt = cnt_q + CNT_W'(1);
  end

  assign emit_o     = fire && cls_i.ok && (cnt_nxt == CNT_FULL) && (cls_i.key != stable_q);
  assign emit_key_o = cls_i.key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= OPEN_BYTE;
      cand_q   <= OPEN_BYTE;
      cnt_q    <= '0;
    end else if (shdn) begin
      stable_q <= OPEN_BYTE;
      cand_q   <= OPEN_BYTE;
      cnt_q    <= '0;
    end else if (fire) begin
      cnt_q <= cnt_nxt;
      if (cls_i.ok) cand_q <= cls_i.key;
      if (emit_o)   stable_q <= cls_i.key;
    end
  end

endmodule

// File: rtl/rkc_evt_out.sv
module rkc_evt_out
  import rkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn,
  input  logic              load,
  input  logic [CODE_W-1:0] load_key,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [CODE_W-1:0] m_key,
  output logic              room_o
);

  assign room_o = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_key   <= OPEN_BYTE;
    end else if (shdn) begin
      m_valid <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_key   <= load_key;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rkc_key_classifier.sv
module rkc_key_classifier
  import rkc_pkg::*;
#(
  parameter int DEBOUNCE_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_code,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_key
);

  cls_t              cls;
  logic              room, fire, emit;
  logic [CODE_W-1:0] emit_key;

  assign s_ready = shdn || room;
  assign fire    = s_valid && room && !shdn;

  rkc_classifier u_cls (
    .code_i (s_code),
    .cls_o  (cls)
  );

  rkc_debounce #(.DEBOUNCE_N(DEBOUNCE_N)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn       (shdn),
    .fire       (fire),
    .cls_i      (cls),
    .emit_o     (emit),
    .emit_key_o (emit_key)
  );

  rkc_evt_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn     (shdn),
    .load     (emit),
    .load_key (emit_key),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .m_key    (m_key),
    .room_o   (room)
  );

endmodule

// File: rtl/rkc_key_classifier_chk.sv
module rkc_key_classifier_chk
  import rkc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       shdn,
  input logic       s_valid,
  input logic       s_ready,
  input logic [7:0] s_code,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_key
);

  logic       in_gap;
  logic [7:0] last_q;

  always_comb begin
    in_gap = 1'b1;
    for (int w = 0; w < NUM_WIN; w++)
      if (s_code >= win_lo(w) && s_code <= win_hi(w)) in_gap = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 last_q <= OPEN_BYTE;
    else if (shdn)              last_q <= OPEN_BYTE;
    else if (m_valid && m_ready) last_q <= m_key;
  end

  // R7
  hold_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !shdn) |=> (m_valid && $stable(m_key)));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !shdn) |-> !s_ready);

  // R8
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !m_valid);

  // R8
  shdn_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> s_ready);

  // R3
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !shdn && in_gap) |=> !m_valid);

  // R1 R2
  key_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_key < 8'd30 || m_key == JACK_IN_BYTE || m_key == OPEN_BYTE));

  // R5
  change_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> (m_key != last_q));

endmodule

bind rkc_key_classifier rkc_key_classifier_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .shdn    (shdn),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_code  (s_code),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_key   (m_key)
);

// File: tb/rkc_key_classifier_tb.sv
module rkc_key_classifier_tb;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shdn = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_code = 8'd0;
  logic       m_ready = 1'b1;
  logic       s_ready, m_valid;
  logic [7:0] m_key;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  rkc_key_classifier #(.DEBOUNCE_N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn(shdn), .s_valid(s_valid), .s_ready(s_ready),
    .s_code(s_code), .m_valid(m_valid), .m_ready(m_ready), .m_key(m_key)
  );

  int lo_t[32] = '{0,11,19,27,35,42,50,58,66,74,82,90,98,105,114,123,130,137,146,154,
                   162,170,178,186,194,202,211,218,226,235,243,254};
  int hi_t[32] = '{1,13,21,30,38,46,53,62,70,78,86,94,102,110,119,127,135,142,150,159,
                   166,174,182,190,198,206,214,222,229,237,245,255};

  function automatic int classify(int c);
    for (int i = 0; i < 32; i++)
      if (c >= lo_t[i] && c <= hi_t[i]) return (i < 30) ? i : (i == 30 ? 'hF3 : 'hFE);
    return -1;
  endfunction

  // Behavioural reference model
  int md_stable = 'hFE, md_cand = -1, md_cnt = 0, md_key = 'hFE;
  bit md_valid = 0;
  int ev_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      md_stable = 'hFE; md_cand = -1; md_cnt = 0; md_valid = 0;
    end else if (shdn) begin
      md_stable = 'hFE; md_cand = -1; md_cnt = 0; md_valid = 0;
    end else begin
      bit rdy;
      rdy = !md_valid || m_ready;
      if (md_valid && m_ready) begin
        ev_q.push_back(m_key);
        md_valid = 0;
      end
      if (s_valid && rdy) begin
        int c;
        c = classify(s_code);
        if (c < 0) md_cnt = 0;
        else begin
          if (md_cnt > 0 && c == md_cand) md_cnt = (md_cnt < N) ? md_cnt + 1 : N;
          else md_cnt = 1;
          md_cand = c;
          if (md_cnt == N && c != md_stable) begin
            md_stable = c; md_valid = 1; md_key = c;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      check("R4 R9 m_valid vs model", m_valid, md_valid);
      if (md_valid) check("R1 R2 R5 m_key vs model", m_key, md_key);
      check("R7 R8 s_ready vs model", s_ready, shdn || !md_valid || m_ready);
    end
  end

  int base = 0;
  task automatic mark(); base = ev_q.size(); endtask

  task automatic send(input int code, input int n);
    repeat (n) begin
      @(negedge clk); s_valid = 1'b1; s_code = 8'(code);
    end
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic chk_ev(input string tag, input int n_exp, input int key_exp);
    repeat (2) @(negedge clk);
    #2;
    check({tag, " event count"}, ev_q.size() - base, n_exp);
    if (n_exp > 0 && ev_q.size() > 0) check({tag, " event key"}, ev_q[$], key_exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R6 reset m_valid", m_valid, 0);
    check("R6 reset s_ready", s_ready, 1);
    cmp_on = 1;

    // R6 R1: first press with no host action, key 0 at window top
    mark(); send(1, N);   chk_ev("R6 R1 key0", 1, 0);
    // R3: gap codes, long run
    mark(); send(5, 10);  chk_ev("R3 gap run", 0, 0);
    // R4: one short, then completing sample
    mark(); send(255, N-1); chk_ev("R4 short run", 0, 0);
    send(255, 1);         chk_ev("R4 run completes", 1, 'hFE);
    // R3: invalid sample breaks the run
    mark(); send(28, N-1); send(7, 1); send(28, N-1); chk_ev("R3 broken run", 0, 0);
    send(28, 1);          chk_ev("R1 key3 after restart", 1, 3);
    // R1: window edges
    mark(); send(235, N); chk_ev("R1 key29 low edge", 1, 29);
    mark(); send(238, N); chk_ev("R3 gap above key29", 0, 0);
    mark(); send(98, N);  chk_ev("R1 key12 low edge", 1, 12);
    // R2
    mark(); send(244, N); chk_ev("R2 jack insert", 1, 'hF3);
    // R5: excursion then key-to-key
    mark(); send(100, N); chk_ev("R5 key12", 1, 12);
    mark(); send(170, N-1); send(100, N); chk_ev("R5 excursion", 0, 0);
    mark(); send(174, N); chk_ev("R5 key to key", 1, 21);
    mark(); send(254, N); chk_ev("R5 release", 1, 'hFE);

    // R7: back-pressure
    m_ready = 1'b0;
    mark(); send(19, N);
    repeat (5) begin
      @(negedge clk); s_valid = 1'b1; s_code = 8'd255;
      #2;
      check("R7 held valid", m_valid, 1);
      check("R7 held key", m_key, 2);
      check("R7 input stalled", s_ready, 0);
    end
    @(negedge clk); s_valid = 1'b0; m_ready = 1'b1;
    chk_ev("R7 released event", 1, 2);

    // R8: shutdown with pending event
    m_ready = 1'b0;
    mark(); send(1, N);
    @(negedge clk); shdn = 1'b1; s_valid = 1'b1; s_code = 8'd100;
    #2; check("R8 ready in shutdown", s_ready, 1);
    @(negedge clk); #2;
    check("R8 pending cleared", m_valid, 0);
    @(negedge clk); shdn = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    mark(); send(255, N); chk_ev("R8 open after shutdown", 0, 0);
    mark(); send(0, N);   chk_ev("R8 press after shutdown", 1, 0);

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int code, len;
      code = $urandom_range(0, 255);
      if ($urandom_range(0, 3) != 0) code = lo_t[$urandom_range(0, 31)];
      len = $urandom_range(1, 7);
      for (int j = 0; j < len; j++) begin
        @(negedge clk);
        s_valid = ($urandom_range(0, 5) != 0);
        s_code  = 8'(code);
        m_ready = ($urandom_range(0, 3) != 0);
        shdn    = ($urandom_range(0, 199) == 0);
      end
    end
    @(negedge clk); s_valid = 1'b0; shdn = 1'b0; m_ready = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule